// File: doc/BRIEF.md
# USB IN Endpoint Retry Controller

This block runs the device side of IN data transactions for a set of transmit endpoints. Firmware arms an endpoint by loading a byte count. When the host sends an IN token to that endpoint, the block answers with a data response. The response carries the DATA0 or DATA1 PID taken from the endpoint's toggle, along with the packet length. The block then steps a buffer read pointer while the serializer pulls bytes.

The host's handshake closes the transaction. An ACK flips the toggle, empties the buffer, moves the packet start past the bytes just sent, and raises that endpoint's completion flag. A timeout (no handshake, or the ACK was lost) rewinds the read pointer to the first byte of the packet and leaves the toggle and the armed buffer as they were. The next IN token then resends the same packet with the same PID. The number of retries has no limit.

A completed SETUP stage on the control endpoint forces both its transmit toggle and its receive toggle to one.

Top module: `usb_in_retry`

## Requirements
- R1: After reset, `resp_valid_o`, `busy_o`, every `tog_o` bit, `rx0_tog_o` and every `irq_o` bit are 0, and `rd_ptr_o` is 0.
- R2: An IN token to an idle, existing endpoint gets a response one cycle later. If `stall_i` for that endpoint is set, the response is STALL (`resp_o` = 2), even when the endpoint is armed. Otherwise, if the endpoint is not armed, the response is NAK (`resp_o` = 1).
- R3: An IN token to an armed, unstalled endpoint gets a DATA response (`resp_o` = 0) one cycle later. `tx_pid_o` equals the endpoint toggle (0 = DATA0, 1 = DATA1), `len_o` equals the loaded count, `busy_o` rises, and `rd_ptr_o` starts at the packet start and increments once per `byte_rd_i`.
- R4: A timeout while busy ends the transaction. `rd_ptr_o` returns to the packet start, the toggle is unchanged and the endpoint stays armed, so every later IN token resends the packet with the same PID and length, any number of times.
- R5: An ACK while busy ends the transaction. The toggle flips, the endpoint becomes unarmed (the next IN gets NAK), and the packet start and `rd_ptr_o` become the old packet start plus the length.
- R6: An endpoint's `irq_o` bit is set only by an ACK on that endpoint. It stays set until `irq_clr_i` for that bit. When set and clear occur in the same cycle, set wins.
- R7: A loaded count is clamped to 64 on every endpoint except the high-capacity one. That endpoint clamps to 512 when `hs_mode_i` is 1 and to 64 otherwise.
- R8: A load to an endpoint that is still armed is ignored; the earlier count stays in force.
- R9: `setup_i` sets the control endpoint's transmit toggle (`tog_o[0]`) and `rx0_tog_o` to 1. This takes priority over a toggle flip from an ACK in the same cycle.
- R10: An IN token that arrives while busy, or that names an endpoint number of `NUM_EP` or more, gets no response. An ACK or timeout that arrives while idle changes nothing.
- R11: When an ACK and a timeout arrive in the same busy cycle, the ACK outcome (R5) applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_mode_i | input | 1 | 1 = high-speed link |
| tok_in_i | input | 1 | IN token strobe |
| tok_ep_i | input | EP_W | Endpoint number of the token |
| byte_rd_i | input | 1 | Serializer consumed one byte |
| hs_ack_i | input | 1 | ACK handshake received |
| timeout_i | input | 1 | No handshake in time |
| setup_i | input | 1 | SETUP stage with 8-byte DATA0 completed on endpoint 0 |
| stall_i | input | NUM_EP | Per-endpoint stall condition |
| load_i | input | 1 | Firmware count load strobe |
| load_ep_i | input | EP_W | Endpoint number for the load |
| load_cnt_i | input | LEN_W | Byte count to load |
| irq_clr_i | input | NUM_EP | Per-endpoint flag clear |
| resp_valid_o | output | 1 | Response pulse |
| resp_o | output | 2 | 0 DATA, 1 NAK, 2 STALL |
| tx_pid_o | output | 1 | 0 DATA0, 1 DATA1 |
| len_o | output | LEN_W | Packet length for DATA |
| busy_o | output | 1 | Transaction awaiting handshake |
| act_ep_o | output | EP_W | Endpoint of the last accepted transaction |
| rd_ptr_o | output | PTR_W | Buffer read pointer of `act_ep_o` |
| tog_o | output | NUM_EP | Transmit toggles |
| rx0_tog_o | output | 1 | Control endpoint receive toggle |
| irq_o | output | NUM_EP | Completion flags |

## Verification
Two pairs of events can share a cycle. The first pair is an ACK together with a timeout, and the bench checks that the toggle flips and the pointer advances. The second pair is a SETUP completion together with an ACK on endpoint 0. For that case the toggle is first brought to 1, so that a lost priority would leave it at 0. A third collision, an ACK with an `irq_clr_i` for the same endpoint, must leave the flag set. Each collision is driven in a single cycle and judged one cycle later at the ports.

// File: rtl/usb_in_retry_pkg.sv
package usb_in_retry_pkg;
  typedef enum logic [1:0] {
    RESP_DATA  = 2'd0,
    RESP_NAK   = 2'd1,
    RESP_STALL = 2'd2
  } resp_e;
endpackage

// File: rtl/inret_ep.sv
module inret_ep #(
  parameter int LEN_W  = 10,
  parameter int PTR_W  = 11,
  parameter bit BIG    = 1'b0,
  parameter int MAX_FS = 64,
  parameter int MAX_HS = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_mode_i,
  input  logic             load_i,
  input  logic [LEN_W-1:0] cnt_i,
  input  logic             start_i,
  input  logic             byte_i,
  input  logic             ack_i,
  input  logic             tmo_i,
  input  logic             setup_i,
  input  logic             irq_clr_i,
  output logic             armed_o,
  output logic [LEN_W-1:0] len_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             tog_o,
  output logic             irq_o
);
  localparam logic [LEN_W-1:0] FS_LIM = LEN_W'(MAX_FS);
  localparam logic [LEN_W-1:0] HS_LIM = LEN_W'(MAX_HS);

  logic [LEN_W-1:0] cap, cnt_lim;
  logic [PTR_W-1:0] base_q, base_nxt;

  assign cap      = (BIG && hs_mode_i) ? HS_LIM : FS_LIM;
  assign cnt_lim  = (cnt_i > cap) ? cap : cnt_i;
  assign base_nxt = base_q + PTR_W'(len_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      len_o   <= '0;
    end else if (ack_i) begin
      armed_o <= 1'b0;
    end else if (load_i && !armed_o) begin
      armed_o <= 1'b1;
      len_o   <= cnt_lim;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ptr_o  <= '0;
    end else if (ack_i) begin
      base_q <= base_nxt;
      ptr_o  <= base_nxt;
    end else if (tmo_i || start_i) begin
      ptr_o  <= base_q;
    end else if (byte_i) begin
      ptr_o  <= ptr_o + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tog_o <= 1'b0;
    else if (setup_i) tog_o <= 1'b1;
    else if (ack_i)   tog_o <= ~tog_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_o <= 1'b0;
    else if (ack_i)     irq_o <= 1'b1;
    else if (irq_clr_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/inret_txn.sv
module inret_txn
  import usb_in_retry_pkg::*;
#(
  parameter int NUM_EP = 3,
  parameter int EP_W   = 2,
  parameter int LEN_W  = 10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tok_in_i,
  input  logic [EP_W-1:0]             tok_ep_i,
  input  logic                        ack_i,
  input  logic                        tmo_i,
  input  logic [NUM_EP-1:0]           stall_i,
  input  logic [NUM_EP-1:0]           armed_i,
  input  logic [NUM_EP-1:0]           tog_i,
  input  logic [NUM_EP-1:0][LEN_W-1:0] len_i,
  output logic [NUM_EP-1:0]           start_o,
  output logic                        busy_o,
  output logic [EP_W-1:0]             act_ep_o,
  output logic                        resp_valid_o,
  output logic [1:0]                  resp_o,
  output logic                        pid_o,
  output logic [LEN_W-1:0]            len_o
);
  logic tok_ok, accept, sel_stall, sel_armed, sel_tog;
  logic [LEN_W-1:0] sel_len;
  resp_e resp_d;

  assign tok_ok = tok_in_i && !busy_o && ({1'b0, tok_ep_i} < (EP_W+1)'(NUM_EP));

  always_comb begin
    sel_stall = 1'b0;
    sel_armed = 1'b0;
    sel_tog   = 1'b0;
    sel_len   = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (tok_ep_i == EP_W'(i)) begin
        sel_stall = stall_i[i];
        sel_armed = armed_i[i];
        sel_tog   = tog_i[i];
        sel_len   = len_i[i];
      end
    end
  end

  assign accept = tok_ok && !sel_stall && sel_armed;

  always_comb begin
    if (sel_stall)      resp_d = RESP_STALL;
    else if (sel_armed) resp_d = RESP_DATA;
    else                resp_d = RESP_NAK;
  end

  for (genvar g = 0; g < NUM_EP; g++) begin : g_start
    assign start_o[g] = accept && (tok_ep_i == EP_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o       <= 1'b0;
      act_ep_o     <= '0;
      resp_valid_o <= 1'b0;
      resp_o       <= RESP_NAK;
      pid_o        <= 1'b0;
      len_o        <= '0;
    end else begin
      resp_valid_o <= tok_ok;
      if (tok_ok) begin
        resp_o <= resp_d;
        pid_o  <= sel_tog;
        len_o  <= accept ? sel_len : '0;
      end
      if (accept) begin
        busy_o   <= 1'b1;
        act_ep_o <= tok_ep_i;
      end else if (busy_o && (ack_i || tmo_i)) begin
        busy_o   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usb_in_retry.sv
module usb_in_retry #(
  parameter int NUM_EP = 3,
  parameter int BIG_EP = 2,
  parameter int MAX_FS = 64,
  parameter int MAX_HS = 512,
  parameter int PTR_W  = 11,
  parameter int LEN_W  = $clog2(MAX_HS + 1),
  parameter int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP + 1) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_mode_i,
  input  logic              tok_in_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  input  logic              byte_rd_i,
  input  logic              hs_ack_i,
  input  logic              timeout_i,
  input  logic              setup_i,
  input  logic [NUM_EP-1:0] stall_i,
  input  logic              load_i,
  input  logic [EP_W-1:0]   load_ep_i,
  input  logic [LEN_W-1:0]  load_cnt_i,
  input  logic [NUM_EP-1:0] irq_clr_i,
  output logic              resp_valid_o,
  output logic [1:0]        resp_o,
  output logic              tx_pid_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              busy_o,
  output logic [EP_W-1:0]   act_ep_o,
  output logic [PTR_W-1:0]  rd_ptr_o,
  output logic [NUM_EP-1:0] tog_o,
  output logic              rx0_tog_o,
  output logic [NUM_EP-1:0] irq_o
);
  logic [NUM_EP-1:0]             armed, start;
  logic [NUM_EP-1:0][LEN_W-1:0]  ep_len;
  logic [NUM_EP-1:0][PTR_W-1:0]  ep_ptr;

  inret_txn #(.NUM_EP(NUM_EP), .EP_W(EP_W), .LEN_W(LEN_W)) u_txn (
    .clk_i, .rst_ni,
    .tok_in_i, .tok_ep_i,
    .ack_i(hs_ack_i), .tmo_i(timeout_i),
    .stall_i, .armed_i(armed), .tog_i(tog_o), .len_i(ep_len),
    .start_o(start), .busy_o, .act_ep_o,
    .resp_valid_o, .resp_o, .pid_o(tx_pid_o), .len_o
  );

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    logic here;
    assign here = busy_o && (act_ep_o == EP_W'(g));
    inret_ep #(
      .LEN_W(LEN_W), .PTR_W(PTR_W), .BIG(g == BIG_EP),
      .MAX_FS(MAX_FS), .MAX_HS(MAX_HS)
    ) u_ep (
      .clk_i, .rst_ni, .hs_mode_i,
      .load_i(load_i && (load_ep_i == EP_W'(g))),
      .cnt_i(load_cnt_i),
      .start_i(start[g]),
      .byte_i(here && byte_rd_i),
      .ack_i(here && hs_ack_i),
      .tmo_i(here && timeout_i && !hs_ack_i),
      .setup_i(setup_i && (g == 0)),
      .irq_clr_i(irq_clr_i[g]),
      .armed_o(armed[g]), .len_o(ep_len[g]), .ptr_o(ep_ptr[g]),
      .tog_o(tog_o[g]), .irq_o(irq_o[g])
    );
  end

  always_comb begin
    rd_ptr_o = '0;
    for (int i = 0; i < NUM_EP; i++)
      if (act_ep_o == EP_W'(i)) rd_ptr_o = ep_ptr[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rx0_tog_o <= 1'b0;
    else if (setup_i) rx0_tog_o <= 1'b1;
  end
endmodule

// File: rtl/usb_in_retry_chk.sv
module usb_in_retry_chk #(
  parameter int NUM_EP = 3,
  parameter int MAX_HS = 512,
  parameter int PTR_W  = 11,
  parameter int LEN_W  = 10,
  parameter int EP_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hs_ack_i,
  input logic              timeout_i,
  input logic              setup_i,
  input logic              resp_valid_o,
  input logic [1:0]        resp_o,
  input logic              tx_pid_o,
  input logic [LEN_W-1:0]  len_o,
  input logic              busy_o,
  input logic [EP_W-1:0]   act_ep_o,
  input logic [NUM_EP-1:0] tog_o,
  input logic              rx0_tog_o,
  input logic [NUM_EP-1:0] irq_o
);
  assert_pid_matches_tog_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_o == 2'd0) |-> (busy_o && tx_pid_o == tog_o[act_ep_o]));

  assert_len_bounded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_o == 2'd0) |-> (len_o <= LEN_W'(MAX_HS)));

  assert_tmo_keeps_tog_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && timeout_i && !hs_ack_i && !setup_i) |=> (tog_o == $past(tog_o)));

  assert_ack_ends_txn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && hs_ack_i) |=> !busy_o);

  assert_irq_only_on_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && hs_ack_i) |=> ((irq_o & ~$past(irq_o)) == '0));

  assert_setup_sets_tog_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_i |=> (tog_o[0] && rx0_tog_o));

  assert_idle_hs_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !setup_i) |=> (tog_o == $past(tog_o)));
endmodule

bind usb_in_retry usb_in_retry_chk #(
  .NUM_EP(NUM_EP), .MAX_HS(MAX_HS), .PTR_W(PTR_W), .LEN_W(LEN_W), .EP_W(EP_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hs_ack_i(hs_ack_i), .timeout_i(timeout_i),
  .setup_i(setup_i), .resp_valid_o(resp_valid_o), .resp_o(resp_o),
  .tx_pid_o(tx_pid_o), .len_o(len_o), .busy_o(busy_o), .act_ep_o(act_ep_o),
  .tog_o(tog_o), .rx0_tog_o(rx0_tog_o), .irq_o(irq_o)
);

// File: tb/tb_usb_in_retry.sv
module tb_usb_in_retry;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP = 3;
  localparam int LEN_W  = 10;
  localparam int PTR_W  = 11;
  localparam int EP_W   = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic hs_mode = 0, tok_in = 0, byte_rd = 0, ack = 0, tmo = 0, setup = 0, load = 0;
  logic [EP_W-1:0] tok_ep = '0, load_ep = '0;
  logic [LEN_W-1:0] load_cnt = '0;
  logic [NUM_EP-1:0] stall = '0, irq_clr = '0;
  logic resp_valid, tx_pid, busy, rx0_tog;
  logic [1:0] resp;
  logic [LEN_W-1:0] len;
  logic [EP_W-1:0] act_ep;
  logic [PTR_W-1:0] rd_ptr;
  logic [NUM_EP-1:0] tog, irq;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_in_retry dut (
    .clk_i(clk), .rst_ni(rst_ni), .hs_mode_i(hs_mode),
    .tok_in_i(tok_in), .tok_ep_i(tok_ep), .byte_rd_i(byte_rd),
    .hs_ack_i(ack), .timeout_i(tmo), .setup_i(setup), .stall_i(stall),
    .load_i(load), .load_ep_i(load_ep), .load_cnt_i(load_cnt), .irq_clr_i(irq_clr),
    .resp_valid_o(resp_valid), .resp_o(resp), .tx_pid_o(tx_pid), .len_o(len),
    .busy_o(busy), .act_ep_o(act_ep), .rd_ptr_o(rd_ptr), .tog_o(tog),
    .rx0_tog_o(rx0_tog), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic in_tok(input int ep);
    tok_in = 1; tok_ep = EP_W'(ep);
    @(negedge clk); tok_in = 0;
  endtask

  task automatic do_load(input int ep, input int cnt);
    load = 1; load_ep = EP_W'(ep); load_cnt = LEN_W'(cnt);
    @(negedge clk); load = 0;
  endtask

  task automatic read_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      byte_rd = 1; @(negedge clk);
    end
    byte_rd = 0;
  endtask

  task automatic hs(input logic a, input logic t, input logic s);
    ack = a; tmo = t; setup = s;
    @(negedge clk); ack = 0; tmo = 0; setup = 0;
  endtask

  task automatic t_reset;
    chk("R1 resp_valid", resp_valid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 tog", tog, 0);
    chk("R1 rx0_tog", rx0_tog, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rd_ptr", rd_ptr, 0);
  endtask

  task automatic t_nak_stall;
    in_tok(1);
    chk("R2 nak valid", resp_valid, 1);
    chk("R2 nak code", resp, 1);
    do_load(1, 10);
    stall[1] = 1;
    in_tok(1);
    chk("R2 stall code", resp, 2);
    chk("R2 stall not busy", busy, 0);
    stall[1] = 0;
  endtask

  task automatic t_retry_then_ack;
    in_tok(1);
    chk("R3 data code", resp, 0);
    chk("R3 pid", tx_pid, 0);
    chk("R3 len", len, 10);
    chk("R3 busy", busy, 1);
    read_bytes(4);
    chk("R3 rd_ptr advance", rd_ptr, 4);
    hs(0, 1, 0);
    chk("R4 rewind", rd_ptr, 0);
    chk("R4 tog kept", tog[1], 0);
    chk("R6 no irq on tmo", irq[1], 0);
    for (int k = 0; k < 3; k++) begin
      in_tok(1);
      chk("R4 resend pid", tx_pid, 0);
      chk("R4 resend len", len, 10);
      read_bytes(k + 2);
      hs(0, 1, 0);
      chk("R4 rewind again", rd_ptr, 0);
    end
    in_tok(1);
    read_bytes(10);
    hs(1, 0, 0);
    chk("R5 tog flip", tog[1], 1);
    chk("R5 rd_ptr past pkt", rd_ptr, 10);
    chk("R5 not busy", busy, 0);
    chk("R6 irq set", irq[1], 1);
    in_tok(1);
    chk("R5 empty -> nak", resp, 1);
    do_load(1, 5);
    in_tok(1);
    chk("R3 pid data1", tx_pid, 1);
    chk("R3 ptr at start", rd_ptr, 10);
    read_bytes(5);
    hs(1, 0, 0);
    chk("R5 ptr 15", rd_ptr, 15);
    chk("R5 tog back", tog[1], 0);
  endtask

  task automatic t_clamp_and_ignore;
    do_load(1, 100);
    do_load(1, 9);
    in_tok(1);
    chk("R7 clamp 64", len, 64);
    chk("R8 reload ignored", len, 64);
    in_tok(0);
    chk("R10 busy token ignored", resp_valid, 0);
    hs(0, 1, 0);
    chk("R4 armed kept", busy, 0);
    in_tok(3);
    chk("R10 bad ep ignored", resp_valid, 0);
    hs(1, 0, 0);
    chk("R10 idle ack ignored", tog[1], 0);
    in_tok(1);
    hs(1, 1, 0);
    chk("R11 ack wins tog", tog[1], 1);
    chk("R11 ack wins ptr", rd_ptr, 79);
    chk("R11 not busy", busy, 0);
    irq_clr[1] = 1; @(negedge clk); irq_clr[1] = 0;
    chk("R6 clear", irq[1], 0);
  endtask

  task automatic t_big_ep;
    do_load(2, 300);
    in_tok(2);
    chk("R7 fs clamp 64", len, 64);
    hs(1, 0, 0);
    hs_mode = 1;
    do_load(2, 600);
    in_tok(2);
    chk("R7 hs clamp 512", len, 512);
    irq_clr[2] = 1; ack = 1;
    @(negedge clk); irq_clr[2] = 0; ack = 0;
    chk("R6 set beats clear", irq[2], 1);
    do_load(2, 300);
    in_tok(2);
    chk("R7 hs 300", len, 300);
    chk("R3 ep2 ptr", rd_ptr, 576);
    hs(0, 1, 0);
  endtask

  task automatic t_setup;
    hs(0, 0, 1);
    chk("R9 tx tog", tog[0], 1);
    chk("R9 rx tog", rx0_tog, 1);
    do_load(0, 8);
    in_tok(0);
    chk("R3 ep0 pid", tx_pid, 1);
    hs(1, 0, 1);
    chk("R9 setup beats ack", tog[0], 1);
    chk("R6 ep0 irq", irq[0], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_nak_stall();
    t_retry_then_ack();
    t_clamp_and_ignore();
    t_big_ep();
    t_setup();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule